// File: doc/BRIEF.md
# Debug Trigger Match-and-Chain Unit

This block watches the instruction-fetch, load and store streams of a core and decides which of ten hardware debug triggers fire in each cycle. Each trigger holds a compare value, a comparison mode and a few control bits. Configuration arrives through two write ports. The fetch-side port addresses the four fetch triggers and the memory-side port addresses the six load and store triggers. Every cycle, each trigger compares its value against the address of its event kind, if that event is present.

The triggers are paired into five groups of fixed kind. A group's chain bit makes its two members fire only together, and only when they request the same trap timing. The registered outputs give the fired triggers, a combined hit, a split between a trap on the current instruction and a trap on the next one, and a request to enter the debug halt state. The pipeline consumes these outputs one cycle after it presents the event.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset all outputs are 0. Every trigger is configured so that it can never fire, which uses less-than mode with compare value 0.
- R2: Fetch-port index 0,1,2,3 writes triggers 0,1,6,8. Memory-port index 0,1,2,3,4,5 writes triggers 2,3,4,5,7,9. Memory indices 6 and 7 write nothing. A write strobed in one cycle applies to events from the next cycle onward.
- R3: Triggers 0,1,6,8 watch fetch, triggers 2,3,7 watch stores and triggers 4,5,9 watch loads. A trigger can hit only while the valid strobe of its own event kind is high, and it compares against that event's address.
- R4: The match-mode field selects the comparison: 0 means equal; 1 means masked equal, where the address bits up to and including the lowest 0 bit of the compare value are ignored; 2 means address >= value; 3 means address < value. All comparisons are unsigned.
- R5: A trigger whose select bit is 1 (data compare, which is unsupported) never hits.
- R6: Bit t of `hit_vec` is trigger t. All outputs are registered, so an event presented in cycle N shows in cycle N+1 and lasts for one cycle only.
- R7: In groups 0, 2, 3 and 4 (triggers 2g and 2g+1), the chain bit of the lower trigger links the pair. While it is set, both triggers fire only if both hit and their timing bits are equal; otherwise neither fires.
- R8: Group 1 (triggers 2 and 3, both store) is never chained, whatever its chain bit.
- R9: `hit_any` is the OR of the fired triggers. `trap_now` is high when a fired trigger has timing 0, and `trap_next` is high when a fired trigger has timing 1.
- R10: `halt_req` is high when any fired trigger has action bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfg_vld | input | 1 | Fetch-side config write strobe |
| fcfg_idx | input | 2 | Fetch-side trigger index |
| fcfg_mode | input | 2 | Match mode |
| fcfg_sel | input | 1 | Select (1 = data compare) |
| fcfg_timing | input | 1 | 0 = trap now, 1 = trap next |
| fcfg_action | input | 1 | 1 = request halt |
| fcfg_chain | input | 1 | Chain bit |
| fcfg_val | input | 64 | Compare value |
| mcfg_vld | input | 1 | Memory-side config write strobe |
| mcfg_idx | input | 3 | Memory-side trigger index |
| mcfg_mode | input | 2 | Match mode |
| mcfg_sel | input | 1 | Select |
| mcfg_timing | input | 1 | Timing |
| mcfg_action | input | 1 | Action |
| mcfg_chain | input | 1 | Chain bit |
| mcfg_val | input | 64 | Compare value |
| fetch_vld | input | 1 | Fetch event present |
| fetch_pc | input | 64 | Fetch address |
| load_vld | input | 1 | Load event present |
| load_addr | input | 64 | Load address |
| store_vld | input | 1 | Store event present |
| store_addr | input | 64 | Store address |
| hit_vec | output | 10 | Fired triggers |
| hit_any | output | 1 | Any trigger fired |
| trap_now | output | 1 | A fired trigger has timing 0 |
| trap_next | output | 1 | A fired trigger has timing 1 |
| halt_req | output | 1 | A fired trigger has action 1 |

## Verification
Several properties are checked in every cycle. A trigger never hits without its own event strobe, and never hits with select set. No trigger fires unless its comparator hit in the cycle before. A chained pair always reports equal fire bits, and the store pair passes its hits straight through. A halt request never appears without a hit.

The directed scenarios show what these invariants cannot. They check the exact index-to-trigger mapping of both write ports, the four comparison modes at their boundaries, the suppression of a chained pair on a timing mismatch, and the one-cycle latency and single-cycle pulse of the outputs.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
    parameter int NUM_GRP     = 5;
    parameter int NUM_TRIG    = 2 * NUM_GRP;
    parameter int CMP_W       = 64;
    parameter int FETCH_IDX_W = 2;
    parameter int MEM_IDX_W   = 3;

    typedef enum logic [1:0] {
        EV_FETCH = 2'd0,
        EV_LOAD  = 2'd1,
        EV_STORE = 2'd2
    } ev_kind_e;

    typedef enum logic [1:0] {
        MT_EQ   = 2'd0,
        MT_MASK = 2'd1,
        MT_GE   = 2'd2,
        MT_LT   = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e              mode;
        logic               sel;
        logic               timing;
        logic               action;
        logic               chain;
        logic [CMP_W-1:0]   val;
    } trig_cfg_t;

    typedef struct packed {
        logic [NUM_TRIG-1:0] fired;
        logic                any;
        logic                trap_cur;
        logic                trap_nx;
        logic                halt;
    } trig_out_t;

    // Disabled setting: "address < 0" can never be true.
    localparam trig_cfg_t CFG_OFF = '{mode: MT_LT, sel: 1'b0, timing: 1'b0,
                                      action: 1'b0, chain: 1'b0, val: '0};

    // Fixed group kinds: fetch/fetch, store/store, load/load, fetch/store, fetch/load
    function automatic ev_kind_e trig_kind(input int t);
        ev_kind_e k;
        case (t / 2)
            0:       k = EV_FETCH;
            1:       k = EV_STORE;
            2:       k = EV_LOAD;
            3:       k = (t % 2 == 1) ? EV_STORE : EV_FETCH;
            default: k = (t % 2 == 1) ? EV_LOAD  : EV_FETCH;
        endcase
        return k;
    endfunction

    // Position of trigger t among the triggers written through the same port
    function automatic int port_slot(input int t);
        int n;
        n = 0;
        for (int k = 0; k < t; k++) begin
            if ((trig_kind(k) == EV_FETCH) == (trig_kind(t) == EV_FETCH)) n++;
        end
        return n;
    endfunction

    // Two store triggers may not be linked
    function automatic bit grp_chainable(input int g);
        return !(trig_kind(2*g) == EV_STORE && trig_kind(2*g+1) == EV_STORE);
    endfunction
endpackage

// File: rtl/dtu_cfg_regs.sv
module dtu_cfg_regs
    import dtu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   f_vld,
    input  logic [FETCH_IDX_W-1:0] f_idx,
    input  trig_cfg_t              f_cfg,
    input  logic                   m_vld,
    input  logic [MEM_IDX_W-1:0]   m_idx,
    input  trig_cfg_t              m_cfg,
    output trig_cfg_t              cfg_o [NUM_TRIG]
);
    trig_cfg_t cfg_d [NUM_TRIG];
    trig_cfg_t cfg_q [NUM_TRIG];

    always_comb begin
        for (int t = 0; t < NUM_TRIG; t++) begin
            cfg_d[t] = cfg_q[t];
            if (trig_kind(t) == EV_FETCH) begin
                if (f_vld && f_idx == FETCH_IDX_W'(port_slot(t))) cfg_d[t] = f_cfg;
            end else begin
                if (m_vld && m_idx == MEM_IDX_W'(port_slot(t))) cfg_d[t] = m_cfg;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int t = 0; t < NUM_TRIG; t++) begin
            if (!rst_n) cfg_q[t] <= CFG_OFF;
            else        cfg_q[t] <= cfg_d[t];
        end
    end

    always_comb begin
        for (int t = 0; t < NUM_TRIG; t++) cfg_o[t] = cfg_q[t];
    end
endmodule

// File: rtl/dtu_match.sv
module dtu_match
    import dtu_pkg::*;
(
    input  mode_e            mode,
    input  logic             sel,
    input  logic [CMP_W-1:0] val,
    input  logic             ev_vld,
    input  logic [CMP_W-1:0] ev_addr,
    output logic             hit
);
    logic [CMP_W-1:0] care;
    logic             cmp_ok;

    always_comb begin
        // ones from bit 0 up to and including the lowest zero of val are ignored
        care = ~(val ^ (val + CMP_W'(1)));
        case (mode)
            MT_EQ:   cmp_ok = (ev_addr == val);
            MT_MASK: cmp_ok = ((ev_addr ^ val) & care) == '0;
            MT_GE:   cmp_ok = (ev_addr >= val);
            default: cmp_ok = (ev_addr <  val);
        endcase
        hit = ev_vld && !sel && cmp_ok;
    end
endmodule

// File: rtl/dtu_chain.sv
module dtu_chain
    import dtu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TRIG-1:0] raw_hit,
    input  logic [NUM_TRIG-1:0] timing,
    input  logic [NUM_TRIG-1:0] action,
    input  logic [NUM_TRIG-1:0] chain,
    output trig_out_t           out_o
);
    logic [NUM_GRP-1:0] chain_on;
    trig_out_t          out_d;
    trig_out_t          out_q;

    always_comb begin
        for (int g = 0; g < NUM_GRP; g++) chain_on[g] = grp_chainable(g) && chain[2*g];
    end

    always_comb begin
        out_d       = '0;
        out_d.fired = raw_hit;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (chain_on[g]) begin
                out_d.fired[2*g]   = raw_hit[2*g] && raw_hit[2*g+1] && (timing[2*g] == timing[2*g+1]);
                out_d.fired[2*g+1] = out_d.fired[2*g];
            end
        end
        for (int t = 0; t < NUM_TRIG; t++) begin
            if (out_d.fired[t]) begin
                out_d.any = 1'b1;
                if (timing[t]) out_d.trap_nx  = 1'b1;
                else           out_d.trap_cur = 1'b1;
                if (action[t]) out_d.halt     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_o = out_q;

    // R6
    fired_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.fired & ~$past(raw_hit)) == '0);

    // R10
    halt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.halt |-> out_q.any);

    // R9
    trap_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.any == (out_q.trap_cur || out_q.trap_nx));

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_chk
        if (grp_chainable(g)) begin : g_linked
            // R7
            pair_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(chain_on[g]) |-> (out_q.fired[2*g] == out_q.fired[2*g+1]));
        end else begin : g_free
            // R8
            store_pair_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(raw_hit[2*g]) |-> out_q.fired[2*g]);
        end
    end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
    import dtu_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fcfg_vld,
    input  logic [FETCH_IDX_W-1:0] fcfg_idx,
    input  logic [1:0]             fcfg_mode,
    input  logic                   fcfg_sel,
    input  logic                   fcfg_timing,
    input  logic                   fcfg_action,
    input  logic                   fcfg_chain,
    input  logic [CMP_W-1:0]       fcfg_val,
    input  logic                   mcfg_vld,
    input  logic [MEM_IDX_W-1:0]   mcfg_idx,
    input  logic [1:0]             mcfg_mode,
    input  logic                   mcfg_sel,
    input  logic                   mcfg_timing,
    input  logic                   mcfg_action,
    input  logic                   mcfg_chain,
    input  logic [CMP_W-1:0]       mcfg_val,
    input  logic                   fetch_vld,
    input  logic [CMP_W-1:0]       fetch_pc,
    input  logic                   load_vld,
    input  logic [CMP_W-1:0]       load_addr,
    input  logic                   store_vld,
    input  logic [CMP_W-1:0]       store_addr,
    output logic [NUM_TRIG-1:0]    hit_vec,
    output logic                   hit_any,
    output logic                   trap_now,
    output logic                   trap_next,
    output logic                   halt_req
);
    trig_cfg_t           f_cfg;
    trig_cfg_t           m_cfg;
    trig_cfg_t           cfg [NUM_TRIG];
    logic [NUM_TRIG-1:0] ev_vld;
    logic [CMP_W-1:0]    ev_addr [NUM_TRIG];
    logic [NUM_TRIG-1:0] raw_hit;
    logic [NUM_TRIG-1:0] timing_v;
    logic [NUM_TRIG-1:0] action_v;
    logic [NUM_TRIG-1:0] chain_v;
    trig_out_t           res;

    assign f_cfg = '{mode: mode_e'(fcfg_mode), sel: fcfg_sel, timing: fcfg_timing,
                     action: fcfg_action, chain: fcfg_chain, val: fcfg_val};
    assign m_cfg = '{mode: mode_e'(mcfg_mode), sel: mcfg_sel, timing: mcfg_timing,
                     action: mcfg_action, chain: mcfg_chain, val: mcfg_val};

    dtu_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .f_vld (fcfg_vld),
        .f_idx (fcfg_idx),
        .f_cfg (f_cfg),
        .m_vld (mcfg_vld),
        .m_idx (mcfg_idx),
        .m_cfg (m_cfg),
        .cfg_o (cfg)
    );

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        localparam ev_kind_e KIND = trig_kind(t);
        if (KIND == EV_FETCH) begin : g_fetch
            assign ev_vld[t]  = fetch_vld;
            assign ev_addr[t] = fetch_pc;
        end else if (KIND == EV_LOAD) begin : g_load
            assign ev_vld[t]  = load_vld;
            assign ev_addr[t] = load_addr;
        end else begin : g_store
            assign ev_vld[t]  = store_vld;
            assign ev_addr[t] = store_addr;
        end

        assign timing_v[t] = cfg[t].timing;
        assign action_v[t] = cfg[t].action;
        assign chain_v[t]  = cfg[t].chain;

        dtu_match u_match (
            .mode    (cfg[t].mode),
            .sel     (cfg[t].sel),
            .val     (cfg[t].val),
            .ev_vld  (ev_vld[t]),
            .ev_addr (ev_addr[t]),
            .hit     (raw_hit[t])
        );

        // R3
        kind_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ev_vld[t] |-> !raw_hit[t]);

        // R5
        sel_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[t].sel |-> !raw_hit[t]);
    end

    dtu_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_hit (raw_hit),
        .timing  (timing_v),
        .action  (action_v),
        .chain   (chain_v),
        .out_o   (res)
    );

    assign hit_vec   = res.fired;
    assign hit_any   = res.any;
    assign trap_now  = res.trap_cur;
    assign trap_next = res.trap_nx;
    assign halt_req  = res.halt;
endmodule

// File: tb/dbg_trig_unit_tb_top.sv
`timescale 1ns/1ps
module dbg_trig_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fcfg_vld = 0, mcfg_vld = 0;
    logic [1:0]  fcfg_idx = 0;
    logic [2:0]  mcfg_idx = 0;
    logic [1:0]  fcfg_mode = 0, mcfg_mode = 0;
    logic        fcfg_sel = 0, fcfg_timing = 0, fcfg_action = 0, fcfg_chain = 0;
    logic        mcfg_sel = 0, mcfg_timing = 0, mcfg_action = 0, mcfg_chain = 0;
    logic [63:0] fcfg_val = 0, mcfg_val = 0;
    logic        fetch_vld = 0, load_vld = 0, store_vld = 0;
    logic [63:0] fetch_pc = 0, load_addr = 0, store_addr = 0;
    logic [9:0]  hit_vec;
    logic        hit_any, trap_now, trap_next, halt_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbg_trig_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .fcfg_vld(fcfg_vld), .fcfg_idx(fcfg_idx), .fcfg_mode(fcfg_mode), .fcfg_sel(fcfg_sel),
        .fcfg_timing(fcfg_timing), .fcfg_action(fcfg_action), .fcfg_chain(fcfg_chain), .fcfg_val(fcfg_val),
        .mcfg_vld(mcfg_vld), .mcfg_idx(mcfg_idx), .mcfg_mode(mcfg_mode), .mcfg_sel(mcfg_sel),
        .mcfg_timing(mcfg_timing), .mcfg_action(mcfg_action), .mcfg_chain(mcfg_chain), .mcfg_val(mcfg_val),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .load_vld(load_vld), .load_addr(load_addr),
        .store_vld(store_vld), .store_addr(store_addr),
        .hit_vec(hit_vec), .hit_any(hit_any), .trap_now(trap_now), .trap_next(trap_next), .halt_req(halt_req)
    );

    // {hit_vec, hit_any, trap_now, trap_next, halt_req}
    task automatic chk(input string tag, input logic [9:0] hv, input logic now, input logic nx, input logic hlt);
        logic [13:0] act, exp;
        act = {hit_vec, hit_any, trap_now, trap_next, halt_req};
        exp = {hv, |hv, now, nx, hlt};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr_f(input logic [1:0] idx, input logic [1:0] mode, input logic sel,
                        input logic tim, input logic act, input logic chn, input logic [63:0] v);
        @(negedge clk);
        fcfg_vld = 1; fcfg_idx = idx; fcfg_mode = mode; fcfg_sel = sel;
        fcfg_timing = tim; fcfg_action = act; fcfg_chain = chn; fcfg_val = v;
        @(negedge clk);
        fcfg_vld = 0;
    endtask

    task automatic wr_m(input logic [2:0] idx, input logic [1:0] mode, input logic sel,
                        input logic tim, input logic act, input logic chn, input logic [63:0] v);
        @(negedge clk);
        mcfg_vld = 1; mcfg_idx = idx; mcfg_mode = mode; mcfg_sel = sel;
        mcfg_timing = tim; mcfg_action = act; mcfg_chain = chn; mcfg_val = v;
        @(negedge clk);
        mcfg_vld = 0;
    endtask

    // Present an event for one cycle; return at the negedge where its result is visible.
    task automatic ev(input logic fv, input logic lv, input logic sv, input logic [63:0] a);
        @(negedge clk);
        fetch_vld = fv; load_vld = lv; store_vld = sv;
        fetch_pc = a; load_addr = a; store_addr = a;
        @(negedge clk);
        fetch_vld = 0; load_vld = 0; store_vld = 0;
    endtask

    task automatic t_reset();
        chk("R1 outputs after reset", 10'h000, 0, 0, 0);
        ev(1, 1, 1, 64'h0);
        chk("R1 unconfigured triggers silent", 10'h000, 0, 0, 0);
    endtask

    task automatic t_fetch_eq();
        wr_f(0, 0, 0, 0, 0, 0, 64'h1000);
        ev(1, 0, 0, 64'h1000);
        chk("R6 R9 R10 fetch equal hit trigger0", 10'h001, 1, 0, 0);
        @(negedge clk);
        chk("R6 hit lasts one cycle", 10'h000, 0, 0, 0);
        ev(0, 1, 0, 64'h1000);
        chk("R3 load does not match fetch trigger", 10'h000, 0, 0, 0);
        ev(1, 0, 0, 64'h1004);
        chk("R4 equal mode miss", 10'h000, 0, 0, 0);
    endtask

    task automatic t_modes();
        wr_f(1, 1, 0, 0, 0, 0, 64'h2007);
        ev(1, 0, 0, 64'h2003); chk("R4 masked hit low bits", 10'h002, 1, 0, 0);
        ev(1, 0, 0, 64'h2008); chk("R4 masked hit bit3 ignored", 10'h002, 1, 0, 0);
        ev(1, 0, 0, 64'h2010); chk("R4 masked miss bit4", 10'h000, 0, 0, 0);
        wr_f(1, 2, 0, 0, 0, 0, 64'h3000);
        ev(1, 0, 0, 64'h3000); chk("R4 ge at bound", 10'h002, 1, 0, 0);
        ev(1, 0, 0, 64'h2fff); chk("R4 ge below", 10'h000, 0, 0, 0);
        wr_f(1, 3, 0, 0, 0, 0, 64'h3000);
        ev(1, 0, 0, 64'h2fff); chk("R4 lt below", 10'h002, 1, 0, 0);
        ev(1, 0, 0, 64'h3000); chk("R4 lt at bound", 10'h000, 0, 0, 0);
        wr_f(1, 3, 0, 0, 0, 0, 64'h0);
    endtask

    task automatic t_mapping();
        wr_m(0, 0, 0, 0, 0, 0, 64'h40);
        wr_m(2, 0, 0, 0, 0, 0, 64'h40);
        wr_m(4, 0, 0, 0, 0, 0, 64'h40);
        wr_m(5, 0, 0, 0, 0, 0, 64'h40);
        wr_f(2, 0, 0, 0, 0, 0, 64'h40);
        wr_f(3, 0, 0, 0, 0, 0, 64'h40);
        ev(0, 0, 1, 64'h40); chk("R2 R3 store triggers 2 and 7", 10'h084, 1, 0, 0);
        ev(0, 1, 0, 64'h40); chk("R2 R3 load triggers 4 and 9", 10'h210, 1, 0, 0);
        ev(1, 0, 0, 64'h40); chk("R2 R3 fetch triggers 6 and 8", 10'h140, 1, 0, 0);
        wr_m(6, 0, 0, 0, 0, 0, 64'h40);
        wr_m(7, 0, 0, 0, 0, 0, 64'h40);
        ev(0, 0, 1, 64'h40); chk("R2 memory index 6 and 7 write nothing", 10'h084, 1, 0, 0);
        ev(0, 1, 0, 64'h40); chk("R2 loads unchanged after index 6 and 7", 10'h210, 1, 0, 0);
    endtask

    task automatic t_select();
        wr_m(1, 0, 1, 0, 0, 0, 64'h40);
        ev(0, 0, 1, 64'h40); chk("R5 select set blocks trigger3", 10'h084, 1, 0, 0);
    endtask

    task automatic t_chain();
        wr_f(2, 0, 0, 0, 0, 1, 64'h40);
        ev(1, 0, 0, 64'h40); chk("R7 chained fetch half alone", 10'h100, 1, 0, 0);
        ev(0, 0, 1, 64'h40); chk("R7 chained store half alone", 10'h004, 1, 0, 0);
        ev(1, 0, 1, 64'h40); chk("R7 chained pair both hit", 10'h1c4, 1, 0, 0);
        wr_m(4, 0, 0, 1, 0, 0, 64'h40);
        ev(1, 0, 1, 64'h40); chk("R7 timing mismatch kills pair", 10'h104, 1, 0, 0);
        wr_f(0, 0, 0, 0, 0, 1, 64'h1000);
        wr_f(1, 0, 0, 0, 0, 0, 64'h1000);
        ev(1, 0, 0, 64'h1000); chk("R7 group0 chained both", 10'h003, 1, 0, 0);
        wr_f(1, 0, 0, 1, 0, 0, 64'h1000);
        ev(1, 0, 0, 64'h1000); chk("R7 group0 timing mismatch", 10'h000, 0, 0, 0);
        wr_f(1, 0, 0, 0, 0, 0, 64'h1004);
        ev(1, 0, 0, 64'h1000); chk("R7 group0 one member misses", 10'h000, 0, 0, 0);
    endtask

    task automatic t_store_pair();
        wr_m(0, 0, 0, 0, 0, 1, 64'h40);
        ev(0, 0, 1, 64'h40); chk("R8 store pair chain bit ignored", 10'h004, 1, 0, 0);
    endtask

    task automatic t_timing_action();
        wr_m(5, 0, 0, 1, 1, 0, 64'h40);
        ev(0, 1, 0, 64'h40); chk("R9 R10 both timings and halt", 10'h210, 1, 1, 1);
        wr_m(2, 3, 0, 0, 0, 0, 64'h0);
        ev(0, 1, 0, 64'h40); chk("R9 R10 trap next only", 10'h200, 0, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fetch_eq();
        t_modes();
        t_mapping();
        t_select();
        t_chain();
        t_store_pair();
        t_timing_action();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule